// File: doc/BRIEF.md
# Configurable Pin Function Crossbar

This block connects a bank of general-purpose pins to a set of on-chip digital peripherals. Each pin holds a small function code and a direction bit, written through a simple address, data and write-enable port. From these two fields the crossbar computes three things for each pin: the value to drive, whether the driver is enabled, and whether the pin acts as open-drain. It also decides which peripheral input, if any, receives the level seen on the pin.

The peripheral side covers the following:
- a comparator output;
- three clock outputs;
- two timers with capture inputs and compare outputs;
- a DMA trigger input;
- two serial units;
- three radio status lines.

Serial unit A works as UART or SPI. Serial unit B works as SPI or I2C. For serial and radio functions the owning peripheral decides the pin direction. In I2C mode unit B's data lines only ever pull low. If one unit's clock is mapped to any pin, the other unit's slave-enable input is blocked and that unit falls back to 3-wire SPI.

Only the mapping registers are clocked. Every other path, from registers and peripheral signals to pins and peripheral inputs, is combinational. A new mapping therefore takes effect right after the clock edge that stores it.

Top module: `pinxbar`

## Requirements
- R1: After reset every pin holds code 0 with input direction. All pin_oe and pin_out bits are low, and every peripheral input sits at its idle level.
- R2: Code 0 and every code from 24 to 31 have no function. With dir=1 the pin drives pin_out=0 with pin_oe=1. With dir=0 the pin feeds no peripheral input.
- R3: The paired codes are listed below. With dir=1 the pin drives the output source with pin_oe=1. With dir=0, pin_oe=0 and the pin level feeds the paired input.
  - Code 1 pairs the comparator output with the timer-0 clock input.
  - Code 2 pairs the comparator output with the timer-1 clock input.
  - Codes 7, 8 and 9 pair timer-0 compare outputs with timer-0 capture inputs, channels 0, 1 and 2.
  - Codes 10, 11 and 12 do the same for timer 1, channels 0, 1 and 2.
- R4: Codes 3, 4 and 5 are output-only: auxiliary, main and sub clock. With dir=1 the pin drives that clock. With dir=0, pin_oe=0 and the pin feeds nothing.
- R5: Code 6 is input-only (DMA trigger). With dir=0 the pin level drives dma_trig. With dir=1 the pin drives low with pin_oe=1.
- R6: Some codes are peripheral-directed, and for these the dir bit is ignored. Codes 13–16 are unit A's data0, data1, clock and slave enable. Codes 17–20 are the same four lines for unit B. Codes 21–23 are radio lines 0–2. For each such code:
  - pin_oe comes from the owner's enable: sa_oe/sb_oe bit 0 for data0, bit 1 for data1, bit 2 for clock, and radio_oe[k] for radio line k.
  - A slave-enable pin is never driven.
  - The pin always feeds the owner's input.
- R7: With sb_i2c_mode=1, codes 17 and 18 act as open-drain. pin_out is 0 and pin_od is 1. pin_oe is the inverse of the unit's value (sb_somi for 17, sb_simo for 18).
- R8: Unit A's data codes follow sa_spi_mode:
  - Code 13 input goes to sa_rxd when sa_spi_mode=0 and to sa_somi_in when sa_spi_mode=1.
  - Code 14 outputs sa_txd when sa_spi_mode=0 and sa_simo when sa_spi_mode=1.
  - Code 14 input reaches sa_simo_in only in SPI mode.
- R9: When any pin holds code 15 (A clock), the code-20 input is blocked, sb_ste_in stays 1 and sb_4w_eff is 0 whatever sb_4w_cfg says. The mirror rule applies: code 19 blocks code 16, forcing sa_ste_in to 1 and sa_4w_eff to 0.
- R10: When several pins feed the same input, the lowest-numbered pin wins. An input fed by no pin rests at 1 for serial inputs and at 0 for timer, DMA and radio inputs.
- R11: pin_out is low whenever pin_oe is low.
- R12: On a rising clock edge with wr_en=1, pin wr_addr takes wr_code and wr_dir and no other pin changes. With wr_en=0 no mapping changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the mapping registers |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Mapping write strobe |
| wr_addr | input | AW | Pin index to write |
| wr_code | input | CODE_W | Function code to store |
| wr_dir | input | 1 | Direction to store (1 = output) |
| pin_in | input | NUM_PINS | Levels seen on the pins |
| pin_out | output | NUM_PINS | Pin output values |
| pin_oe | output | NUM_PINS | Pin driver enables |
| pin_od | output | NUM_PINS | Pin is in open-drain mode |
| cmp_out | input | 1 | Comparator output |
| clk_aux | input | 1 | Auxiliary clock |
| clk_main | input | 1 | Main clock |
| clk_sub | input | 1 | Sub clock |
| tmr0_out | input | TMR_CH | Timer 0 compare outputs |
| tmr1_out | input | TMR_CH | Timer 1 compare outputs |
| tmr0_clk_in | output | 1 | Timer 0 external clock input |
| tmr1_clk_in | output | 1 | Timer 1 external clock input |
| tmr0_cap | output | TMR_CH | Timer 0 capture inputs |
| tmr1_cap | output | TMR_CH | Timer 1 capture inputs |
| dma_trig | output | 1 | DMA external trigger |
| sa_spi_mode | input | 1 | Unit A mode (0 UART, 1 SPI) |
| sa_4w_cfg | input | 1 | Unit A configured for 4-wire SPI |
| sa_txd | input | 1 | Unit A UART transmit |
| sa_simo | input | 1 | Unit A SPI SIMO output |
| sa_somi | input | 1 | Unit A SPI SOMI output |
| sa_sclk | input | 1 | Unit A clock output |
| sa_oe | input | 3 | Unit A enables: data0, data1, clock |
| sa_rxd | output | 1 | Unit A UART receive |
| sa_somi_in | output | 1 | Unit A SOMI input |
| sa_simo_in | output | 1 | Unit A SIMO input |
| sa_sclk_in | output | 1 | Unit A clock input |
| sa_ste_in | output | 1 | Unit A slave-enable input |
| sa_4w_eff | output | 1 | Unit A effective 4-wire mode |
| sb_i2c_mode | input | 1 | Unit B mode (0 SPI, 1 I2C) |
| sb_4w_cfg | input | 1 | Unit B configured for 4-wire SPI |
| sb_simo | input | 1 | Unit B SIMO / SDA output value |
| sb_somi | input | 1 | Unit B SOMI / SCL output value |
| sb_sclk | input | 1 | Unit B clock output |
| sb_oe | input | 3 | Unit B enables: data0, data1, clock |
| sb_somi_in | output | 1 | Unit B SOMI / SCL input |
| sb_simo_in | output | 1 | Unit B SIMO / SDA input |
| sb_sclk_in | output | 1 | Unit B clock input |
| sb_ste_in | output | 1 | Unit B slave-enable input |
| sb_4w_eff | output | 1 | Unit B effective 4-wire mode |
| radio_o | input | RADIO_N | Radio status line values |
| radio_oe | input | RADIO_N | Radio status line enables |
| radio_in | output | RADIO_N | Radio status line inputs |

## Verification
The main function is tried with a table of single-pin mappings. Each row sets one code and direction and drives every peripheral source to the same level. Rows with the source at 1 and at 0 show whether the pin follows the source or is tied low. Rows that flip the direction bit separate dir-steered codes from peripheral-steered ones. Rows that flip the serial modes show whether UART or SPI data is chosen, and whether a push-pull or open-drain driver is used. Directed input tests then place two pins on one input at opposite levels, which exposes the pin priority. They also map one unit's clock while the other unit's slave enable is held low, which exposes the precedence rule.

// File: rtl/pinxbar_pkg.sv
package pinxbar_pkg;

  // Peripheral counts
  localparam int TMR_CH  = 3;
  localparam int RADIO_N = 3;

  // Function code assignments
  localparam int C_NONE       = 0;
  localparam int C_CMP_T0     = 1;
  localparam int C_CMP_T1     = 2;
  localparam int C_CLK_AUX    = 3;
  localparam int C_CLK_MAIN   = 4;
  localparam int C_CLK_SUB    = 5;
  localparam int C_DMA        = 6;
  localparam int C_T0_BASE    = 7;
  localparam int C_T1_BASE    = C_T0_BASE + TMR_CH;
  localparam int C_SA_D0      = C_T1_BASE + TMR_CH;
  localparam int C_SA_D1      = C_SA_D0 + 1;
  localparam int C_SA_CLK     = C_SA_D0 + 2;
  localparam int C_SA_STE     = C_SA_D0 + 3;
  localparam int C_SB_D0      = C_SA_D0 + 4;
  localparam int C_SB_D1      = C_SA_D0 + 5;
  localparam int C_SB_CLK     = C_SA_D0 + 6;
  localparam int C_SB_STE     = C_SA_D0 + 7;
  localparam int C_RADIO_BASE = C_SB_STE + 1;
  localparam int N_CODES      = C_RADIO_BASE + RADIO_N;

  typedef enum logic [2:0] {
    K_NONE,
    K_PAIRED,
    K_OUT_ONLY,
    K_IN_ONLY,
    K_PERIPH
  } fn_kind_e;

  // Classify a function code
  function automatic fn_kind_e code_kind(input int c);
    if (c == C_CMP_T0 || c == C_CMP_T1)                  return K_PAIRED;
    if (c >= C_T0_BASE && c < C_SA_D0)                   return K_PAIRED;
    if (c >= C_CLK_AUX && c <= C_CLK_SUB)                return K_OUT_ONLY;
    if (c == C_DMA)                                      return K_IN_ONLY;
    if (c >= C_SA_D0 && c < C_RADIO_BASE + RADIO_N)      return K_PERIPH;
    return K_NONE;
  endfunction

  // Whether a pin with this kind and direction feeds a peripheral input
  function automatic logic accepts_input(input fn_kind_e k, input logic dir);
    if (k == K_PAIRED || k == K_IN_ONLY) return !dir;
    return (k == K_PERIPH);
  endfunction

  // Whether the dir bit routes the source onto the pin
  function automatic logic dir_drives_source(input fn_kind_e k);
    return (k == K_PAIRED || k == K_OUT_ONLY);
  endfunction

endpackage

// File: rtl/pxb_map_regs.sv
module pxb_map_regs #(
  parameter int NUM_PINS = 8,
  parameter int CODE_W   = 5,
  parameter int AW       = 3,
  localparam int NSLOT   = 1 << CODE_W
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               wr_en,
  input  logic [AW-1:0]                      wr_addr,
  input  logic [CODE_W-1:0]                  wr_code,
  input  logic                               wr_dir,
  output logic [NUM_PINS-1:0][CODE_W-1:0]    code_q,
  output logic [NUM_PINS-1:0]                dir_q,
  output logic [NSLOT-1:0]                   code_used
);

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic hit_w;
    assign hit_w = wr_en && (wr_addr == AW'(p));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        code_q[p] <= '0;
        dir_q[p]  <= 1'b0;
      end else if (hit_w) begin
        code_q[p] <= wr_code;
        dir_q[p]  <= wr_dir;
      end
    end
  end

  always_comb begin
    code_used = '0;
    for (int p = 0; p < NUM_PINS; p++) code_used[code_q[p]] = 1'b1;
  end

endmodule

// File: rtl/pxb_pin_drive.sv
module pxb_pin_drive
  import pinxbar_pkg::*;
#(
  parameter int CODE_W = 5,
  localparam int NSLOT = 1 << CODE_W
) (
  input  logic [CODE_W-1:0] code,
  input  logic              dir,
  input  logic [NSLOT-1:0]  src_val,
  input  logic [NSLOT-1:0]  src_oe,
  input  logic [NSLOT-1:0]  src_od,
  output logic              pin_out,
  output logic              pin_oe,
  output logic              pin_od
);

  fn_kind_e kind;
  logic     val;

  assign kind = code_kind(int'(code));
  assign val  = src_val[code];

  always_comb begin
    pin_od = 1'b0;
    if (kind == K_PERIPH) begin
      if (src_od[code]) begin
        pin_od  = 1'b1;
        pin_oe  = !val;
        pin_out = 1'b0;
      end else begin
        pin_oe  = src_oe[code];
        pin_out = val & src_oe[code];
      end
    end else begin
      pin_oe  = dir;
      pin_out = dir & dir_drives_source(kind) & val;
    end
  end

endmodule

// File: rtl/pxb_in_route.sv
module pxb_in_route
  import pinxbar_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int CODE_W   = 5,
  localparam int NSLOT   = 1 << CODE_W
) (
  input  logic [NUM_PINS-1:0]              pin_in,
  input  logic [NUM_PINS-1:0][CODE_W-1:0]  code_q,
  input  logic [NUM_PINS-1:0]              dir_q,
  input  logic [NSLOT-1:0]                 block,
  output logic [NSLOT-1:0]                 sink_hit,
  output logic [NSLOT-1:0]                 sink_val
);

  // Scan from the highest pin down so the lowest-numbered pin wins
  always_comb begin
    sink_hit = '0;
    sink_val = '0;
    for (int p = NUM_PINS - 1; p >= 0; p--) begin
      if (accepts_input(code_kind(int'(code_q[p])), dir_q[p]) && !block[code_q[p]]) begin
        sink_hit[code_q[p]] = 1'b1;
        sink_val[code_q[p]] = pin_in[p];
      end
    end
  end

endmodule

// File: rtl/pinxbar.sv
module pinxbar
  import pinxbar_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int CODE_W   = 5,
  localparam int AW      = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [AW-1:0]        wr_addr,
  input  logic [CODE_W-1:0]    wr_code,
  input  logic                 wr_dir,
  input  logic [NUM_PINS-1:0]  pin_in,
  output logic [NUM_PINS-1:0]  pin_out,
  output logic [NUM_PINS-1:0]  pin_oe,
  output logic [NUM_PINS-1:0]  pin_od,
  input  logic                 cmp_out,
  input  logic                 clk_aux,
  input  logic                 clk_main,
  input  logic                 clk_sub,
  input  logic [TMR_CH-1:0]    tmr0_out,
  input  logic [TMR_CH-1:0]    tmr1_out,
  output logic                 tmr0_clk_in,
  output logic                 tmr1_clk_in,
  output logic [TMR_CH-1:0]    tmr0_cap,
  output logic [TMR_CH-1:0]    tmr1_cap,
  output logic                 dma_trig,
  input  logic                 sa_spi_mode,
  input  logic                 sa_4w_cfg,
  input  logic                 sa_txd,
  input  logic                 sa_simo,
  input  logic                 sa_somi,
  input  logic                 sa_sclk,
  input  logic [2:0]           sa_oe,
  output logic                 sa_rxd,
  output logic                 sa_somi_in,
  output logic                 sa_simo_in,
  output logic                 sa_sclk_in,
  output logic                 sa_ste_in,
  output logic                 sa_4w_eff,
  input  logic                 sb_i2c_mode,
  input  logic                 sb_4w_cfg,
  input  logic                 sb_simo,
  input  logic                 sb_somi,
  input  logic                 sb_sclk,
  input  logic [2:0]           sb_oe,
  output logic                 sb_somi_in,
  output logic                 sb_simo_in,
  output logic                 sb_sclk_in,
  output logic                 sb_ste_in,
  output logic                 sb_4w_eff,
  input  logic [RADIO_N-1:0]   radio_o,
  input  logic [RADIO_N-1:0]   radio_oe,
  output logic [RADIO_N-1:0]   radio_in
);

  localparam int NSLOT = 1 << CODE_W;

  logic [NUM_PINS-1:0][CODE_W-1:0] code_q;
  logic [NUM_PINS-1:0]             dir_q;
  logic [NSLOT-1:0]                code_used;
  logic [NSLOT-1:0]                src_val, src_oe, src_od, block;
  logic [NSLOT-1:0]                sink_hit, sink_val;

  // Named events for the checker
  logic sa_clk_taken, sb_clk_taken;
  assign sa_clk_taken = code_used[C_SA_CLK];
  assign sb_clk_taken = code_used[C_SB_CLK];

  pxb_map_regs #(.NUM_PINS(NUM_PINS), .CODE_W(CODE_W), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_code(wr_code), .wr_dir(wr_dir),
    .code_q(code_q), .dir_q(dir_q), .code_used(code_used)
  );

  // Output source table, indexed by function code
  always_comb begin
    src_val = '0;
    src_oe  = '0;
    src_od  = '0;
    src_val[C_CMP_T0]   = cmp_out;
    src_val[C_CMP_T1]   = cmp_out;
    src_val[C_CLK_AUX]  = clk_aux;
    src_val[C_CLK_MAIN] = clk_main;
    src_val[C_CLK_SUB]  = clk_sub;
    for (int k = 0; k < TMR_CH; k++) begin
      src_val[C_T0_BASE + k] = tmr0_out[k];
      src_val[C_T1_BASE + k] = tmr1_out[k];
    end
    src_val[C_SA_D0]  = sa_spi_mode ? sa_somi : 1'b1;
    src_val[C_SA_D1]  = sa_spi_mode ? sa_simo : sa_txd;
    src_val[C_SA_CLK] = sa_sclk;
    src_val[C_SB_D0]  = sb_somi;
    src_val[C_SB_D1]  = sb_simo;
    src_val[C_SB_CLK] = sb_sclk;
    for (int k = 0; k < 3; k++) begin
      src_oe[C_SA_D0 + k] = sa_oe[k];
      src_oe[C_SB_D0 + k] = sb_oe[k];
    end
    src_od[C_SB_D0] = sb_i2c_mode;
    src_od[C_SB_D1] = sb_i2c_mode;
    for (int k = 0; k < RADIO_N; k++) begin
      src_val[C_RADIO_BASE + k] = radio_o[k];
      src_oe[C_RADIO_BASE + k]  = radio_oe[k];
    end
  end

  // Cross-unit precedence: a mapped clock blocks the other unit's slave enable
  always_comb begin
    block = '0;
    block[C_SB_STE] = sa_clk_taken;
    block[C_SA_STE] = sb_clk_taken;
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_drv
    pxb_pin_drive #(.CODE_W(CODE_W)) u_drv (
      .code(code_q[p]), .dir(dir_q[p]),
      .src_val(src_val), .src_oe(src_oe), .src_od(src_od),
      .pin_out(pin_out[p]), .pin_oe(pin_oe[p]), .pin_od(pin_od[p])
    );
  end

  pxb_in_route #(.NUM_PINS(NUM_PINS), .CODE_W(CODE_W)) u_route (
    .pin_in(pin_in), .code_q(code_q), .dir_q(dir_q), .block(block),
    .sink_hit(sink_hit), .sink_val(sink_val)
  );

  // Peripheral inputs with idle levels
  assign tmr0_clk_in = sink_hit[C_CMP_T0] & sink_val[C_CMP_T0];
  assign tmr1_clk_in = sink_hit[C_CMP_T1] & sink_val[C_CMP_T1];
  assign dma_trig    = sink_hit[C_DMA] & sink_val[C_DMA];

  for (genvar k = 0; k < TMR_CH; k++) begin : g_cap
    assign tmr0_cap[k] = sink_hit[C_T0_BASE + k] & sink_val[C_T0_BASE + k];
    assign tmr1_cap[k] = sink_hit[C_T1_BASE + k] & sink_val[C_T1_BASE + k];
  end

  for (genvar k = 0; k < RADIO_N; k++) begin : g_rad
    assign radio_in[k] = sink_hit[C_RADIO_BASE + k] & sink_val[C_RADIO_BASE + k];
  end

  assign sa_rxd     = (!sa_spi_mode && sink_hit[C_SA_D0]) ? sink_val[C_SA_D0] : 1'b1;
  assign sa_somi_in = ( sa_spi_mode && sink_hit[C_SA_D0]) ? sink_val[C_SA_D0] : 1'b1;
  assign sa_simo_in = ( sa_spi_mode && sink_hit[C_SA_D1]) ? sink_val[C_SA_D1] : 1'b1;
  assign sa_sclk_in = sink_hit[C_SA_CLK] ? sink_val[C_SA_CLK] : 1'b1;
  assign sa_ste_in  = sink_hit[C_SA_STE] ? sink_val[C_SA_STE] : 1'b1;
  assign sa_4w_eff  = sa_4w_cfg & ~sb_clk_taken;

  assign sb_somi_in = sink_hit[C_SB_D0]  ? sink_val[C_SB_D0]  : 1'b1;
  assign sb_simo_in = sink_hit[C_SB_D1]  ? sink_val[C_SB_D1]  : 1'b1;
  assign sb_sclk_in = sink_hit[C_SB_CLK] ? sink_val[C_SB_CLK] : 1'b1;
  assign sb_ste_in  = sink_hit[C_SB_STE] ? sink_val[C_SB_STE] : 1'b1;
  assign sb_4w_eff  = sb_4w_cfg & ~sa_clk_taken;

  // Sinks with no peripheral behind them
  logic unused_sinks;
  assign unused_sinks = ^{sink_hit, sink_val};

endmodule

// File: rtl/pinxbar_chk.sv
module pinxbar_chk #(
  parameter int NUM_PINS = 8,
  parameter int CODE_W   = 5,
  parameter int AW       = 3
) (
  input logic                              clk,
  input logic                              rst_n,
  input logic                              wr_en,
  input logic [AW-1:0]                     wr_addr,
  input logic [CODE_W-1:0]                 wr_code,
  input logic [NUM_PINS-1:0][CODE_W-1:0]   code_q,
  input logic [NUM_PINS-1:0]               pin_out,
  input logic [NUM_PINS-1:0]               pin_oe,
  input logic [NUM_PINS-1:0]               pin_od,
  input logic                              sa_clk_taken,
  input logic                              sb_clk_taken,
  input logic                              sa_ste_in,
  input logic                              sb_ste_in,
  input logic                              sa_4w_eff,
  input logic                              sb_4w_eff
);

  AST_RESET_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (pin_oe == '0)); // R1

  AST_OUT_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_out & ~pin_oe) == '0)); // R11

  AST_OD_LOW_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_od & pin_out) == '0)); // R7

  AST_B_FORCED_3W: assert property (@(posedge clk) disable iff (!rst_n)
    sa_clk_taken |-> (!sb_4w_eff && sb_ste_in)); // R9

  AST_A_FORCED_3W: assert property (@(posedge clk) disable iff (!rst_n)
    sb_clk_taken |-> (!sa_4w_eff && sa_ste_in)); // R9

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (code_q[$past(wr_addr)] == $past(wr_code))); // R12

endmodule

bind pinxbar pinxbar_chk #(.NUM_PINS(NUM_PINS), .CODE_W(CODE_W), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_code(wr_code),
  .code_q(code_q), .pin_out(pin_out), .pin_oe(pin_oe), .pin_od(pin_od),
  .sa_clk_taken(sa_clk_taken), .sb_clk_taken(sb_clk_taken),
  .sa_ste_in(sa_ste_in), .sb_ste_in(sb_ste_in),
  .sa_4w_eff(sa_4w_eff), .sb_4w_eff(sb_4w_eff)
);

// File: tb/pinxbar_test.sv
`timescale 1ns/1ps
module pinxbar_test;

  localparam int N = 8;
  localparam int CW = 5;
  localparam int TC = 3;
  localparam int RN = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [CW-1:0] wr_code = '0;
  logic wr_dir = 1'b0;
  logic [N-1:0] pin_in = '0;
  logic [N-1:0] pin_out, pin_oe, pin_od;
  logic cmp_out = 0, clk_aux = 0, clk_main = 0, clk_sub = 0;
  logic [TC-1:0] tmr0_out = '0, tmr1_out = '0;
  logic tmr0_clk_in, tmr1_clk_in, dma_trig;
  logic [TC-1:0] tmr0_cap, tmr1_cap;
  logic sa_spi_mode = 0, sa_4w_cfg = 1, sa_txd = 0, sa_simo = 0, sa_somi = 0, sa_sclk = 0;
  logic [2:0] sa_oe = '0;
  logic sa_rxd, sa_somi_in, sa_simo_in, sa_sclk_in, sa_ste_in, sa_4w_eff;
  logic sb_i2c_mode = 0, sb_4w_cfg = 1, sb_simo = 0, sb_somi = 0, sb_sclk = 0;
  logic [2:0] sb_oe = '0;
  logic sb_somi_in, sb_simo_in, sb_sclk_in, sb_ste_in, sb_4w_eff;
  logic [RN-1:0] radio_o = '0, radio_oe = '0, radio_in;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pinxbar #(.NUM_PINS(N), .CODE_W(CW)) uut (.*);

  typedef struct packed {
    logic [3:0]  req;
    logic [2:0]  pin;
    logic [4:0]  code;
    logic        dir, src, uoe, spi, i2c, exp_oe, exp_out;
  } vec_t;

  localparam vec_t VECS [0:16] = '{
    '{4'd2,  3'd0, 5'd0,  1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
    '{4'd2,  3'd1, 5'd27, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
    '{4'd3,  3'd2, 5'd1,  1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1},
    '{4'd3,  3'd3, 5'd1,  1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{4'd3,  3'd4, 5'd8,  1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
    '{4'd3,  3'd5, 5'd11, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1},
    '{4'd4,  3'd6, 5'd4,  1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1},
    '{4'd4,  3'd7, 5'd5,  1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{4'd5,  3'd0, 5'd6,  1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
    '{4'd6,  3'd1, 5'd21, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1},
    '{4'd6,  3'd2, 5'd22, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{4'd6,  3'd3, 5'd15, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1},
    '{4'd7,  3'd4, 5'd18, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},
    '{4'd7,  3'd5, 5'd18, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
    '{4'd7,  3'd6, 5'd17, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1},
    '{4'd8,  3'd7, 5'd14, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1},
    '{4'd8,  3'd0, 5'd14, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input int p, input int c, input logic d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'(p); wr_code = CW'(c); wr_dir = d;
    @(negedge clk);
    wr_en = 1'b0;
    #1;
  endtask

  task automatic clear_all();
    for (int p = 0; p < N; p++) wr(p, 0, 1'b0);
  endtask

  task automatic set_src(input logic s, input logic uoe, input logic spi, input logic i2c);
    cmp_out = s; clk_aux = s; clk_main = s; clk_sub = s;
    tmr0_out = {TC{s}}; tmr1_out = {TC{s}};
    sa_txd = s; sa_simo = ~s; sa_somi = s; sa_sclk = s; sa_oe = {3{uoe}};
    sb_simo = s; sb_somi = s; sb_sclk = s; sb_oe = {3{uoe}};
    radio_o = {RN{s}}; radio_oe = {RN{uoe}};
    sa_spi_mode = spi; sb_i2c_mode = i2c;
    #1;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // R1: reset state
    chk("R1 pin_oe", pin_oe, '0);
    chk("R1 pin_out", pin_out, '0);
    chk("R1 idle serial", {sa_rxd, sa_ste_in, sb_ste_in, sb_somi_in}, 4'hF);
    chk("R1 idle other", {tmr0_clk_in, dma_trig, radio_in}, '0);

    // Table walk over output behaviour
    for (int i = 0; i < 17; i++) begin
      vec_t v = VECS[i];
      set_src(v.src, v.uoe, v.spi, v.i2c);
      wr(int'(v.pin), int'(v.code), v.dir);
      chk($sformatf("R%0d vec%0d oe", v.req, i), pin_oe[v.pin], v.exp_oe);
      chk($sformatf("R%0d vec%0d out", v.req, i), pin_out[v.pin], v.exp_out);
      if (v.req == 4'd7) chk($sformatf("R7 vec%0d od", i), pin_od[v.pin], v.i2c);
      wr(int'(v.pin), 0, 1'b0);
    end
    set_src(1'b0, 1'b0, 1'b0, 1'b0);
    clear_all();

    // R3: paired input side
    wr(2, 1, 1'b0);
    pin_in = 8'h04; #1;
    chk("R3 tmr0 clk in high", tmr0_clk_in, 1'b1);
    pin_in = 8'h00; #1;
    chk("R3 tmr0 clk in low", tmr0_clk_in, 1'b0);
    wr(3, 9, 1'b0);
    pin_in = 8'h08; #1;
    chk("R3 tmr0 cap ch2", tmr0_cap, 3'b100);
    clear_all();

    // R4 and R2: no feed
    wr(1, 3, 1'b0);
    wr(2, 0, 1'b0);
    pin_in = 8'hFF; #1;
    chk("R4 clk code input feeds nothing", {tmr0_clk_in, tmr1_clk_in, dma_trig, tmr0_cap, tmr1_cap, radio_in}, '0);
    chk("R4 clk code input oe", pin_oe[1], 1'b0);
    chk("R2 code0 input feeds nothing", {sa_rxd, sa_somi_in, sb_ste_in}, 3'b111);
    clear_all();

    // R5: DMA input
    wr(4, 6, 1'b0);
    pin_in = 8'h10; #1;
    chk("R5 dma trig", dma_trig, 1'b1);
    clear_all();

    // R8: unit A data0 input steering
    wr(5, 13, 1'b1);
    pin_in = 8'h00; sa_spi_mode = 1'b0; #1;
    chk("R8 uart rxd", {sa_rxd, sa_somi_in}, 2'b01);
    sa_spi_mode = 1'b1; #1;
    chk("R8 spi somi", {sa_rxd, sa_somi_in}, 2'b10);
    sa_spi_mode = 1'b0;
    clear_all();

    // R6: radio input ignores dir
    wr(6, 23, 1'b1);
    pin_in = 8'h40; #1;
    chk("R6 radio in", radio_in, 3'b100);
    clear_all();

    // R10: lowest pin wins, both orders
    wr(1, 6, 1'b0);
    wr(6, 6, 1'b0);
    pin_in = 8'h40; #1;
    chk("R10 lowest pin low", dma_trig, 1'b0);
    pin_in = 8'h02; #1;
    chk("R10 lowest pin high", dma_trig, 1'b1);
    clear_all();

    // R9: precedence, both directions
    pin_in = 8'h00;
    wr(0, 20, 1'b0); #1;
    chk("R9 B ste follows pin", {sb_ste_in, sb_4w_eff}, 2'b01);
    wr(7, 15, 1'b0);
    chk("R9 A clk forces B 3-wire", {sb_ste_in, sb_4w_eff}, 2'b10);
    clear_all();
    wr(0, 16, 1'b0); #1;
    chk("R9 A ste follows pin", {sa_ste_in, sa_4w_eff}, 2'b01);
    wr(7, 19, 1'b0);
    chk("R9 B clk forces A 3-wire", {sa_ste_in, sa_4w_eff}, 2'b10);
    clear_all();

    // R12: write without strobe ignored, write touches one pin only
    @(negedge clk);
    wr_en = 1'b0; wr_addr = 3'd3; wr_code = 5'd0; wr_dir = 1'b1;
    @(negedge clk); #1;
    chk("R12 no strobe no change", pin_oe, '0);
    wr(3, 0, 1'b1);
    chk("R12 single pin written", pin_oe, 8'h08);
    // R11: every undriven pin output low
    chk("R11 undriven pins low", pin_out & ~pin_oe, '0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule